// File: doc/BRIEF.md
# DisplayPort Hot-Plug-Detect Transceiver

This block drives or watches the hot-plug-detect line of a display link through one bidirectional pin. A mode input picks the role. As a transmitter it turns command strobes into the line waveforms a display source expects. An assert strobe raises the line and holds it up for a guaranteed minimum time. A deassert strobe drops it. An interrupt strobe produces a timed low pulse and then returns the line high.

As a receiver it synchronises the pin and qualifies a rising level with a high debounce window. The window is short or long, chosen by one select bit. Once the line is qualified high, each low excursion is timed by its width. A very short low is treated as a glitch and discarded. A low of moderate width is an interrupt. A low that stays down long enough is a disconnect.

Each receive event produces a one-cycle pulse and also sets a sticky status bit. A rejected transmit interrupt request sets a sticky status bit as well. A clear strobe resets all the sticky bits. Every duration is derived from a clock-frequency parameter.

Top module: `hpd_xcvr`

## Requirements
- R1: After reset, `hpd_o` is 0, `connected_o` is 0, `status_o` is 0 and no event pulse is active. `hpd_oe_o` equals `mode_i` at all times (1 = transmit, 0 = receive).
- R2: In transmit mode, an `assert_i` strobe taken while the line is low makes `hpd_o` high from the next cycle. The line then stays high for at least 3.33 ms of clock cycles. A `deassert_i` that arrives inside that window is deferred to the end of the window.
- R3: In transmit mode, a `deassert_i` strobe taken after the minimum high time has elapsed drives `hpd_o` low on the next cycle.
- R4: In transmit mode, an `irq_i` strobe taken while the line is settled high drives `hpd_o` low for exactly 750 µs of clock cycles and then returns it high.
- R5: An `irq_i` strobe is rejected if the line is low, if the minimum high window is still running, or if an interrupt pulse is still in progress. A rejected strobe leaves `hpd_o` unchanged and sets `status_o[3]`.
- R6: In receive mode with `db_long_i` = 0, a rising line is reported as connected only after 375 µs of continuous high. At that point `connected_o` rises and `plug_o` pulses once.
- R7: In receive mode with `db_long_i` = 1, the high debounce window is 111 ms.
- R8: While connected, a low excursion shorter than 375 µs produces no event and leaves `connected_o` at 1.
- R9: While connected, a low excursion of at least 375 µs that returns high before 1.5 ms produces exactly one `irq_o` pulse, and `connected_o` stays 1.
- R10: While connected, a low excursion that reaches 1.5 ms produces one `unplug_o` pulse and drops `connected_o` to 0.
- R11: The sticky status bits are bit0 plug, bit1 unplug, bit2 receive interrupt and bit3 transmit reject. Each bit is set by its event and cleared by `clr_i`. An event that arrives in the same cycle as a clear keeps its bit set.
- R12: In receive mode, transmit strobes have no effect and `hpd_o` stays 0. In transmit mode, the receiver stays idle: `connected_o` is 0 and no receive events occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 1 = transmit role, 0 = receive role |
| db_long_i | input | 1 | Receive high debounce: 0 short, 1 long |
| assert_i | input | 1 | Transmit assert strobe |
| deassert_i | input | 1 | Transmit deassert strobe |
| irq_i | input | 1 | Transmit interrupt pulse strobe |
| clr_i | input | 1 | Clears the sticky status bits |
| hpd_i | input | 1 | Pin input level |
| hpd_o | output | 1 | Pin output level |
| hpd_oe_o | output | 1 | Pin output enable |
| connected_o | output | 1 | Debounced receive state |
| plug_o | output | 1 | One-cycle plug event |
| unplug_o | output | 1 | One-cycle unplug event |
| irq_o | output | 1 | One-cycle receive interrupt event |
| status_o | output | 4 | Sticky event bits |

## Verification
The receive-side tests use low widths exactly one cycle either side of the glitch limit and of the interrupt limit. A classifier using the wrong comparison would turn a glitch into an interrupt, or an interrupt into an unplug, and drop `connected_o`. The transmit tests count the exact high and low cycles after each strobe. A design that failed to defer a deassert would shorten the high time, and a miscounted pulse would be off by a cycle. Interrupt requests are sent while the line is low, while the minimum high window is running and during a pulse; a design that accepted any of them would disturb the line and leave the reject bit clear. A clear is timed to coincide with a receive event, which exposes a design that gives the clear priority.

// File: rtl/hpd_pkg.sv
package hpd_pkg;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_HOLD  = 2'd1,
    TX_HIGH  = 2'd2,
    TX_PULSE = 2'd3
  } tx_state_e;

  // nominal durations in ns
  localparam longint unsigned NS_TX_PULSE = 64'd750_000;
  localparam longint unsigned NS_TX_HOLD  = 64'd3_330_000;
  localparam longint unsigned NS_DB_SHORT = 64'd375_000;
  localparam longint unsigned NS_DB_LONG  = 64'd111_000_000;
  localparam longint unsigned NS_LO_MAX   = 64'd1_500_000;

  localparam int unsigned ST_PLUG   = 0;
  localparam int unsigned ST_UNPLUG = 1;
  localparam int unsigned ST_IRQ    = 2;
  localparam int unsigned ST_TXREJ  = 3;
  localparam int unsigned ST_W      = 4;

  function automatic int unsigned ns_to_cyc(input longint unsigned clk_hz,
                                            input longint unsigned ns);
    longint unsigned c;
    c = (clk_hz * ns) / 64'd1_000_000_000;
    if (c == 0) c = 1;
    return int'(c);
  endfunction

endpackage

// File: rtl/hpd_sync.sv
module hpd_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= {sh_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/hpd_tx.sv
module hpd_tx
  import hpd_pkg::*;
#(
  parameter int unsigned CW      = 16,
  parameter int unsigned T_HOLD  = 100,
  parameter int unsigned T_PULSE = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic assert_i,
  input  logic deassert_i,
  input  logic irq_i,
  output logic lvl_o,
  output logic rej_o
);
  localparam logic [CW-1:0] HOLD_LD  = CW'(T_HOLD - 1);
  localparam logic [CW-1:0] PULSE_LD = CW'(T_PULSE - 1);

  tx_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic          pend_q;   // deassert waiting for a timed phase to end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
      rej_o   <= 1'b0;
    end else if (!en_i) begin
      state_q <= TX_IDLE;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
      rej_o   <= 1'b0;
    end else begin
      rej_o <= irq_i && (state_q != TX_HIGH);
      unique case (state_q)
        TX_IDLE: begin
          pend_q <= 1'b0;
          if (assert_i && !deassert_i) begin
            state_q <= TX_HOLD;
            cnt_q   <= HOLD_LD;
          end
        end
        TX_HIGH: begin
          if (deassert_i) begin
            state_q <= TX_IDLE;
          end else if (irq_i) begin
            state_q <= TX_PULSE;
            cnt_q   <= PULSE_LD;
          end
        end
        TX_HOLD, TX_PULSE: begin
          if (cnt_q == '0) begin
            state_q <= (pend_q || deassert_i) ? TX_IDLE : TX_HIGH;
            pend_q  <= 1'b0;
          end else begin
            cnt_q  <= cnt_q - 1'b1;
            pend_q <= pend_q || deassert_i;
          end
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end

  assign lvl_o = (state_q == TX_HOLD) || (state_q == TX_HIGH);

  // R2
  tx_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lvl_o) |-> ($past(assert_i) || $past(state_q == TX_PULSE)));

  // R5
  tx_rej_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rej_o |-> ($past(irq_i) && $past(en_i)));

  // R4
  tx_pulse_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q == TX_PULSE) && state_q == TX_HIGH) |-> $past(cnt_q == '0));
endmodule

// File: rtl/hpd_rx.sv
module hpd_rx #(
  parameter int unsigned CW         = 16,
  parameter int unsigned T_HI_SHORT = 10,
  parameter int unsigned T_HI_LONG  = 100,
  parameter int unsigned T_LO_DB    = 10,
  parameter int unsigned T_LO_MAX   = 40
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic db_long_i,
  input  logic line_i,
  output logic conn_o,
  output logic plug_o,
  output logic unplug_o,
  output logic irq_o
);
  localparam logic [CW:0] LIM_HS = (CW+1)'(T_HI_SHORT);
  localparam logic [CW:0] LIM_HL = (CW+1)'(T_HI_LONG);
  localparam logic [CW:0] LIM_LD = (CW+1)'(T_LO_DB);
  localparam logic [CW:0] LIM_LM = (CW+1)'(T_LO_MAX);

  logic [CW-1:0] cnt_q;
  logic [CW:0]   cnt_inc;
  logic [CW:0]   hi_lim;

  assign cnt_inc = {1'b0, cnt_q} + (CW+1)'(1);
  assign hi_lim  = db_long_i ? LIM_HL : LIM_HS;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      conn_o   <= 1'b0;
      plug_o   <= 1'b0;
      unplug_o <= 1'b0;
      irq_o    <= 1'b0;
    end else if (!en_i) begin
      cnt_q    <= '0;
      conn_o   <= 1'b0;
      plug_o   <= 1'b0;
      unplug_o <= 1'b0;
      irq_o    <= 1'b0;
    end else begin
      plug_o   <= 1'b0;
      unplug_o <= 1'b0;
      irq_o    <= 1'b0;
      if (!conn_o) begin
        // count continuous high
        if (!line_i) begin
          cnt_q <= '0;
        end else if (cnt_inc >= hi_lim) begin
          cnt_q  <= '0;
          conn_o <= 1'b1;
          plug_o <= 1'b1;
        end else begin
          cnt_q <= cnt_inc[CW-1:0];
        end
      end else begin
        // time each low excursion
        if (!line_i) begin
          if (cnt_inc >= LIM_LM) begin
            cnt_q    <= '0;
            conn_o   <= 1'b0;
            unplug_o <= 1'b1;
          end else begin
            cnt_q <= cnt_inc[CW-1:0];
          end
        end else begin
          if ({1'b0, cnt_q} >= LIM_LD) irq_o <= 1'b1;
          cnt_q <= '0;
        end
      end
    end
  end

  // R9
  rx_evt_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({plug_o, unplug_o, irq_o}));

  // R6
  rx_plug_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    plug_o |-> (conn_o && !$past(conn_o)));

  // R10
  rx_unplug_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unplug_o |-> (!conn_o && $past(conn_o)));

  // R9
  rx_irq_conn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (conn_o && $past(conn_o)));

  // R12
  rx_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!en_i) |-> !conn_o);
endmodule

// File: rtl/hpd_xcvr.sv
module hpd_xcvr
  import hpd_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 24_000_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            mode_i,
  input  logic            db_long_i,
  input  logic            assert_i,
  input  logic            deassert_i,
  input  logic            irq_i,
  input  logic            clr_i,
  input  logic            hpd_i,
  output logic            hpd_o,
  output logic            hpd_oe_o,
  output logic            connected_o,
  output logic            plug_o,
  output logic            unplug_o,
  output logic            irq_o,
  output logic [ST_W-1:0] status_o
);
  localparam int unsigned T_PULSE    = ns_to_cyc(64'(CLK_HZ), NS_TX_PULSE);
  localparam int unsigned T_HOLD     = ns_to_cyc(64'(CLK_HZ), NS_TX_HOLD);
  localparam int unsigned T_DB_SHORT = ns_to_cyc(64'(CLK_HZ), NS_DB_SHORT);
  localparam int unsigned T_DB_LONG  = ns_to_cyc(64'(CLK_HZ), NS_DB_LONG);
  localparam int unsigned T_LO_MAX   = ns_to_cyc(64'(CLK_HZ), NS_LO_MAX);
  localparam int unsigned CW         = $clog2(T_DB_LONG + 2);

  logic line_s;
  logic tx_lvl;
  logic tx_rej;
  logic [ST_W-1:0] status_q;
  logic [ST_W-1:0] evt;

  hpd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (hpd_i),
    .q_o   (line_s)
  );

  hpd_tx #(.CW(CW), .T_HOLD(T_HOLD), .T_PULSE(T_PULSE)) u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (mode_i),
    .assert_i  (assert_i),
    .deassert_i(deassert_i),
    .irq_i     (irq_i),
    .lvl_o     (tx_lvl),
    .rej_o     (tx_rej)
  );

  hpd_rx #(
    .CW        (CW),
    .T_HI_SHORT(T_DB_SHORT),
    .T_HI_LONG (T_DB_LONG),
    .T_LO_DB   (T_DB_SHORT),
    .T_LO_MAX  (T_LO_MAX)
  ) u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (!mode_i),
    .db_long_i(db_long_i),
    .line_i   (line_s),
    .conn_o   (connected_o),
    .plug_o   (plug_o),
    .unplug_o (unplug_o),
    .irq_o    (irq_o)
  );

  always_comb begin
    evt            = '0;
    evt[ST_PLUG]   = plug_o;
    evt[ST_UNPLUG] = unplug_o;
    evt[ST_IRQ]    = irq_o;
    evt[ST_TXREJ]  = tx_rej;
  end

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (clr_i ? '0 : status_q) | evt;
  end

  assign status_o = status_q;
  assign hpd_oe_o = mode_i;
  assign hpd_o    = mode_i & tx_lvl;

  // R11
  st_irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q[ST_IRQ] && !$past(status_q[ST_IRQ])) |-> $past(irq_o));

  // R11
  st_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(status_q[ST_PLUG]) && !$past(clr_i)) |-> status_q[ST_PLUG]);
endmodule

// File: tb/sim_hpd_xcvr.sv
`timescale 1ns/1ps
module sim_hpd_xcvr;
  localparam int unsigned CLK_HZ = 200_000;
  localparam int T_PULSE = int'(longint'(CLK_HZ) * 750 / 1_000_000);
  localparam int T_HOLD  = int'(longint'(CLK_HZ) * 3330 / 1_000_000);
  localparam int T_DBS   = int'(longint'(CLK_HZ) * 375 / 1_000_000);
  localparam int T_DBL   = int'(longint'(CLK_HZ) * 111_000 / 1_000_000);
  localparam int T_LMAX  = int'(longint'(CLK_HZ) * 1500 / 1_000_000);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode = 1'b0, db_long = 1'b0, a_s = 1'b0, d_s = 1'b0, i_s = 1'b0, clr = 1'b0, pin = 1'b0;
  logic hpd_o, hpd_oe_o, connected_o, plug_o, unplug_o, irq_o;
  logic [3:0] status_o;

  int n_chk = 0, n_err = 0;
  int n_plug = 0, n_unplug = 0, n_irq = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hpd_xcvr #(.CLK_HZ(CLK_HZ)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .db_long_i(db_long),
    .assert_i(a_s), .deassert_i(d_s), .irq_i(i_s), .clr_i(clr), .hpd_i(pin),
    .hpd_o(hpd_o), .hpd_oe_o(hpd_oe_o), .connected_o(connected_o),
    .plug_o(plug_o), .unplug_o(unplug_o), .irq_o(irq_o), .status_o(status_o)
  );

  always @(posedge clk) begin
    if (rst_n) begin
      if (plug_o)   n_plug++;
      if (unplug_o) n_unplug++;
      if (irq_o)    n_irq++;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input int which);
    case (which)
      0: a_s = 1'b1;
      1: d_s = 1'b1;
      2: i_s = 1'b1;
      default: clr = 1'b1;
    endcase
    @(negedge clk);
    a_s = 1'b0; d_s = 1'b0; i_s = 1'b0; clr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  endtask

  task automatic t_reset();
    tick(3);
    chk("R1 hpd_o", hpd_o, 0);
    chk("R1 oe", hpd_oe_o, 0);
    chk("R1 connected", connected_o, 0);
    chk("R1 status", status_o, 0);
    rst_n = 1'b1;
    tick(2);
  endtask

  task automatic t_mode();
    strobe(0);
    tick(2);
    chk("R12 rx ignores assert", hpd_o, 0);
    chk("R12 rx oe", hpd_oe_o, 0);
    mode = 1'b1;
    tick(2);
    chk("R12 tx oe", hpd_oe_o, 1);
    chk("R12 no stale assert", hpd_o, 0);
    pin = 1'b1;
    tick(200);
    chk("R12 rx idle conn", connected_o, 0);
    chk("R12 rx idle plug", n_plug, 0);
    pin = 1'b0;
    tick(2);
  endtask

  task automatic t_tx_hold();
    int c = 0;
    a_s = 1'b1;
    @(negedge clk);
    a_s = 1'b0;
    d_s = 1'b1;
    while (hpd_o === 1'b1 && c < 5000) begin
      c++;
      @(negedge clk);
      d_s = 1'b0;
    end
    d_s = 1'b0;
    chk("R2 min high cycles", c, T_HOLD);
    tick(2);
    chk("R2 low after deferred deassert", hpd_o, 0);
  endtask

  task automatic t_tx_deassert_irq();
    int c = 0;
    strobe(0);
    tick(T_HOLD + 5);
    chk("R2 settled high", hpd_o, 1);
    i_s = 1'b1;
    @(negedge clk);
    i_s = 1'b0;
    while (hpd_o === 1'b0 && c < 5000) begin
      c++;
      @(negedge clk);
    end
    chk("R4 irq low cycles", c, T_PULSE);
    chk("R4 high after pulse", hpd_o, 1);
    chk("R4 no reject", status_o[3], 0);
    strobe(1);
    chk("R3 deassert next cycle", hpd_o, 0);
  endtask

  task automatic t_tx_reject();
    strobe(2);
    tick(3);
    chk("R5 reject while low", status_o[3], 1);
    chk("R5 line untouched low", hpd_o, 0);
    strobe(3);
    tick(1);
    chk("R11 clear reject", status_o, 0);
    strobe(0);
    tick(10);
    strobe(2);
    tick(3);
    chk("R5 reject in hold", status_o[3], 1);
    chk("R5 line high in hold", hpd_o, 1);
    strobe(3);
    tick(T_HOLD);
    strobe(2);
    tick(10);
    chk("R4 pulse accepted", status_o[3], 0);
    strobe(2);
    tick(3);
    chk("R5 reject in pulse", status_o[3], 1);
    chk("R5 line low in pulse", hpd_o, 0);
    tick(T_PULSE);
    chk("R5 pulse ends normally", hpd_o, 1);
    strobe(1);
    strobe(3);
    tick(2);
  endtask

  task automatic low_pulse(input int len);
    pin = 1'b0;
    tick(len);
    pin = 1'b1;
    tick(6);
  endtask

  task automatic t_rx_short();
    mode = 1'b0;
    db_long = 1'b0;
    tick(4);
    pin = 1'b1;
    tick(T_DBS);
    chk("R6 not yet connected", connected_o, 0);
    tick(3);
    chk("R6 connected", connected_o, 1);
    chk("R6 one plug", n_plug, 1);
    low_pulse(T_DBS - 1);
    chk("R8 glitch keeps conn", connected_o, 1);
    chk("R8 glitch no irq", n_irq, 0);
    chk("R8 glitch no unplug", n_unplug, 0);
    low_pulse(T_DBS);
    chk("R9 irq at min width", n_irq, 1);
    low_pulse(T_LMAX - 1);
    chk("R9 irq at max width", n_irq, 2);
    chk("R9 still connected", connected_o, 1);
    chk("R11 status plug+irq", status_o, 4'b0101);
  endtask

  task automatic t_clear_race();
    pin = 1'b0;
    tick(2 * T_DBS);
    pin = 1'b1;
    tick(2);
    clr = 1'b1;
    tick(2);
    clr = 1'b0;
    chk("R11 event beats clear", status_o, 4'b0100);
    chk("R9 third irq", n_irq, 3);
    tick(4);
  endtask

  task automatic t_rx_unplug_long();
    pin = 1'b0;
    tick(T_LMAX + 4);
    chk("R10 disconnected", connected_o, 0);
    chk("R10 one unplug", n_unplug, 1);
    chk("R10 no extra irq", n_irq, 3);
    chk("R11 unplug bit", status_o[1], 1);
    db_long = 1'b1;
    tick(2);
    pin = 1'b1;
    tick(T_DBL);
    chk("R7 not yet connected", connected_o, 0);
    tick(3);
    chk("R7 connected", connected_o, 1);
    chk("R7 second plug", n_plug, 2);
  endtask

  initial begin
    fork
      begin
        repeat (200_000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
      end
    join_none
    t_reset();
    t_mode();
    t_tx_hold();
    t_tx_deassert_irq();
    t_tx_reject();
    t_rx_short();
    t_clear_race();
    t_rx_unplug_long();
    finish_run();
  end
endmodule